// File: doc/BRIEF.md
# DC Offset and High-Pass Stage

This block conditions one signed 14-bit ADC channel, one sample at a time. Each valid sample first has a programmable per-channel offset word subtracted from it, with saturation. The result then goes through a fixed first-order recursive DC blocker. The blocker has a zero at DC and a pole at 7569/8192, which puts its -3 dB corner near 0.0225 times half the sample rate.

Either stage can be taken out of the path independently. The offset stage is bypassed when its bypass input is high. The high-pass filter runs only when its disable input is low. Each enabled stage adds one clock of latency, and the valid strobe is delayed to match. A bypassed stage passes its input straight through without a register. A system with several channels places one instance per channel, each with its own offset word.

Top module: `dc_offset_hpf`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_valid` is 0. With both stages enabled, `out_sample` reads 0.
- R2: With `ofs_bypass` = 0, a valid sample produces the value `in_sample - ofs_value`, both operands 14-bit two's complement. The offset word is taken in the same cycle as the sample.
- R3: The offset subtraction saturates to the range -8192 to 8191 instead of wrapping.
- R4: With `ofs_bypass` = 1, `ofs_value` has no effect, and the offset stage adds no register to the path.
- R5: With `hpf_disable` = 0, each sample x reaching the filter updates a state held with 13 fractional bits. The new state is acc' = (x - xp)*8192 + floor(acc*7569/8192), where xp is the previous filter input.
- R6: The filter output is floor((acc' + 4096)/8192), which is round half up, saturated to -8192 to 8191.
- R7: With `hpf_disable` = 1, the filter passes its input unchanged, and its state and previous input are held at zero. After the filter is re-enabled, its first output equals its first input.
- R8: The latency from `in_valid` to `out_valid` equals the number of enabled stages (0, 1 or 2 clocks). When a registered stage receives no valid sample, `out_sample` holds its last value.
- R9: With the filter enabled and a constant input, the output settles to exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a valid input sample |
| in_sample | input | 14 | Signed ADC sample |
| ofs_value | input | 14 | Signed offset to subtract |
| ofs_bypass | input | 1 | 1 = skip the offset stage |
| hpf_disable | input | 1 | 0 = run the high-pass filter, 1 = pass through |
| out_valid | output | 1 | Marks a valid output sample |
| out_sample | output | 14 | Signed conditioned sample |

## Verification
The assertions assume that `ofs_bypass` and `hpf_disable` change only while no sample is in flight. A change of either control redirects the output mux at once, and a sample still inside a register would otherwise reach the output with the wrong latency. The stimulus follows this rule: it drops `in_valid` and idles for several cycles before any change of mode. While a mode is fixed, it varies the sample values, the offset values and the valid density freely, including full-scale and alternating-extreme inputs.

// File: rtl/ofh_pkg.sv
package ofh_pkg;
   localparam int SAMPLE_W     = 14;
   localparam int HPF_POLE_NUM = 7569;
   localparam int HPF_POLE_SH  = 13;
   localparam int HPF_FRAC     = 13;
endpackage

// File: rtl/ofh_offset_sub.sv
module ofh_offset_sub #(
   parameter int DW = ofh_pkg::SAMPLE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bypass,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_data,
   input  logic signed [DW-1:0] offset,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_data
);
   initial begin
      assert (DW >= 4) else $error("ofh_offset_sub: DW too small");
   end

   logic signed [DW:0]   diff;
   logic signed [DW-1:0] clip;
   logic                 v_q;
   logic signed [DW-1:0] d_q;

   assign diff = (DW+1)'(in_data) - (DW+1)'(offset);

   always_comb begin
      if (diff[DW] != diff[DW-1])
         clip = {diff[DW], {(DW-1){~diff[DW]}}};
      else
         clip = diff[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         d_q <= '0;
      end else begin
         v_q <= in_valid;
         if (in_valid) d_q <= clip;
      end
   end

   assign out_valid = bypass ? in_valid : v_q;
   assign out_data  = bypass ? in_data  : d_q;

   // R2
   ofs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && in_valid && offset == '0) |=> (bypass || out_data == $past(in_data)));
   // R3
   ofs_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && in_valid && !in_data[DW-1] && offset[DW-1]) |=> (bypass || !out_data[DW-1]));
endmodule

// File: rtl/ofh_dc_block.sv
module ofh_dc_block #(
   parameter int DW       = ofh_pkg::SAMPLE_W,
   parameter int FRAC     = ofh_pkg::HPF_FRAC,
   parameter int POLE_NUM = ofh_pkg::HPF_POLE_NUM,
   parameter int POLE_SH  = ofh_pkg::HPF_POLE_SH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disable_n_run,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_data,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_data
);
   localparam int GW = DW + 2;
   localparam int AW = GW + FRAC;
   localparam int CW = $clog2(POLE_NUM + 1) + 1;
   localparam int PW = AW + CW;
   localparam logic signed [AW:0] RND  = (AW+1)'(1) <<< (FRAC - 1);
   localparam logic signed [AW:0] OMAX = (AW+1)'((1 << (DW - 1)) - 1);
   localparam logic signed [AW:0] OMIN = ~OMAX;

   initial begin
      assert (FRAC >= 13) else $error("ofh_dc_block: FRAC below 13");
      assert (POLE_NUM < (1 << POLE_SH)) else $error("ofh_dc_block: pole not below one");
      assert (POLE_SH >= 1) else $error("ofh_dc_block: bad pole shift");
   end

   logic signed [AW-1:0] acc, acc_nxt, fb, dx_q;
   logic signed [DW-1:0] xp;
   logic signed [DW:0]   dx;
   logic signed [PW-1:0] prod;
   logic signed [AW:0]   rint;
   logic signed [DW-1:0] y;
   logic                 v_q;

   assign dx      = (DW+1)'(in_data) - (DW+1)'(xp);
   assign dx_q    = AW'(dx) <<< FRAC;
   assign prod    = $signed(PW'(acc)) * $signed(PW'(POLE_NUM));
   assign fb      = AW'(prod >>> POLE_SH);
   assign acc_nxt = dx_q + fb;
   assign rint    = ((AW+1)'(acc) + RND) >>> FRAC;

   always_comb begin
      if (rint > OMAX)      y = OMAX[DW-1:0];
      else if (rint < OMIN) y = OMIN[DW-1:0];
      else                  y = rint[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || disable_n_run) begin
         acc <= '0;
         xp  <= '0;
         v_q <= 1'b0;
      end else begin
         v_q <= in_valid;
         if (in_valid) begin
            acc <= acc_nxt;
            xp  <= in_data;
         end
      end
   end

   assign out_valid = disable_n_run ? in_valid : v_q;
   assign out_data  = disable_n_run ? in_data  : y;

   // R8
   hpf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!disable_n_run && !in_valid) |=> (disable_n_run || $stable(out_data)));
   // R9
   hpf_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!disable_n_run && in_valid && in_data == xp && acc == '0) |=> (disable_n_run || out_data == '0));
endmodule

// File: rtl/dc_offset_hpf.sv
module dc_offset_hpf #(
   parameter int DW       = ofh_pkg::SAMPLE_W,
   parameter int FRAC     = ofh_pkg::HPF_FRAC,
   parameter int POLE_NUM = ofh_pkg::HPF_POLE_NUM,
   parameter int POLE_SH  = ofh_pkg::HPF_POLE_SH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_sample,
   input  logic signed [DW-1:0] ofs_value,
   input  logic                 ofs_bypass,
   input  logic                 hpf_disable,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_sample
);
   logic                 mid_valid;
   logic signed [DW-1:0] mid_data;

   ofh_offset_sub #(.DW(DW)) u_ofs (
      .clk(clk), .rst_n(rst_n), .bypass(ofs_bypass),
      .in_valid(in_valid), .in_data(in_sample), .offset(ofs_value),
      .out_valid(mid_valid), .out_data(mid_data)
   );

   ofh_dc_block #(.DW(DW), .FRAC(FRAC), .POLE_NUM(POLE_NUM), .POLE_SH(POLE_SH)) u_hpf (
      .clk(clk), .rst_n(rst_n), .disable_n_run(hpf_disable),
      .in_valid(mid_valid), .in_data(mid_data),
      .out_valid(out_valid), .out_data(out_sample)
   );

   // R4
   top_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_bypass && hpf_disable) |-> (out_sample == in_sample && out_valid == in_valid));
   // R8
   top_one_stage_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ofs_bypass && hpf_disable && in_valid) |=> (out_valid || ofs_bypass || !hpf_disable));
endmodule

// File: tb/dc_offset_hpf_bench.sv
`timescale 1ns/1ps
module dc_offset_hpf_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [13:0] in_sample = '0;
   logic signed [13:0] ofs_value = '0;
   logic ofs_bypass = 1'b0;
   logic hpf_disable = 1'b0;
   logic out_valid;
   logic signed [13:0] out_sample;

   int checks = 0;
   int errors = 0;
   int lat = 2;
   longint m_acc = 0;
   longint m_xp = 0;
   int hv[3];
   int hd[3];
   int last_out = 0;
   bit have_last = 0;

   always #2.5 clk = ~clk;

   dc_offset_hpf u_dc_offset_hpf (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .ofs_value(ofs_value), .ofs_bypass(ofs_bypass), .hpf_disable(hpf_disable),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic longint sat14(longint v);
      if (v > 8191) return 8191;
      if (v < -8192) return -8192;
      return v;
   endfunction

   function automatic int model(int x, int off);
      longint o;
      o = ofs_bypass ? longint'(x) : sat14(longint'(x) - longint'(off));
      if (hpf_disable) return int'(o);
      m_acc = ((o - m_xp) <<< 13) + ((m_acc * 7569) >>> 13);
      m_xp = o;
      return int'(sat14((m_acc + 4096) >>> 13));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_mode(input bit byp, input bit dis);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      ofs_bypass = byp;
      hpf_disable = dis;
      if (dis) begin m_acc = 0; m_xp = 0; end
      lat = (byp ? 0 : 1) + (dis ? 0 : 1);
      repeat (2) @(negedge clk);
   endtask

   // kind: 0 random, 1 constant, 2 alternating extremes, 3 offset saturation pairs
   task automatic run(input int n, input int kind, input int vpct, input int cval,
                      input int coff, input string req);
      for (int k = 0; k < 3; k++) begin hv[k] = 0; hd[k] = 0; end
      have_last = 0;
      for (int i = 0; i < n + 3; i++) begin
         int x, off;
         bit v;
         @(negedge clk);
         v = (i < n) && (int'($urandom_range(0, 99)) < vpct);
         case (kind)
            0: begin x = int'($urandom_range(0, 16383)) - 8192;
                     off = int'($urandom_range(0, 16383)) - 8192; end
            1: begin x = cval; off = coff; end
            2: begin x = (i % 2 == 1) ? -8192 : 8191; off = 0; end
            default: begin x = (i % 2 == 1) ? -8192 : 8191;
                           off = (i % 2 == 1) ? 8191 : -8192; end
         endcase
         in_valid = v;
         in_sample = 14'(x);
         ofs_value = 14'(off);
         hv[2] = hv[1]; hd[2] = hd[1];
         hv[1] = hv[0]; hd[1] = hd[0];
         hv[0] = v;
         hd[0] = v ? model(x, off) : 0;
         #1;
         check(out_valid == hv[lat][0], {req, "/R8 valid"}, int'(out_valid), hv[lat]);
         if (hv[lat] != 0) begin
            check(int'(out_sample) == hd[lat], req, int'(out_sample), hd[lat]);
            last_out = int'(out_sample);
            have_last = 1;
         end else if (lat > 0 && have_last) begin
            check(int'(out_sample) == last_out, "R8 hold", int'(out_sample), last_out);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0dc1));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      check(out_sample == '0, "R1 sample in reset", int'(out_sample), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(out_sample == '0, "R1 sample after reset", int'(out_sample), 0);

      set_mode(0, 1);
      run(300, 0, 70, 0, 0, "R2 offset random");
      run(40, 3, 100, 0, 0, "R3 offset saturation");
      run(20, 1, 100, 8191, -8192, "R3 positive clip");
      run(20, 1, 100, -8192, 8191, "R3 negative clip");

      set_mode(1, 1);
      run(200, 0, 60, 0, 0, "R4 offset ignored");

      set_mode(1, 0);
      run(400, 0, 80, 0, 0, "R5 filter random");
      run(60, 2, 100, 0, 0, "R6 filter saturation");

      set_mode(0, 0);
      run(400, 0, 50, 0, 0, "R5 both stages");
      run(400, 1, 100, 4000, 1500, "R9 constant input");
      check(last_out == 0, "R9 settled output", last_out, 0);
      run(400, 1, 100, -7000, 900, "R9 negative constant");
      check(last_out == 0, "R9 settled negative", last_out, 0);

      set_mode(1, 1);
      run(30, 0, 100, 0, 0, "R7 filter disabled");
      set_mode(1, 0);
      run(1, 1, 100, 1234, 0, "R7 first after enable");
      check(last_out == 1234, "R7 first output", last_out, 1234);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule